// File: doc/BRIEF.md
# Outbound Peer Destination Registers

This block holds the IPv4 address and the UDP port to which outgoing event datagrams are sent. Two sources can set the pair. The first is a configuration write on a small register bus that carries an offset, write data and a write strobe. The second is learning from inbound traffic. An upstream parser presents the header fields of each received datagram together with a one-cycle valid strobe. When a datagram is addressed to a fixed local listening port, the block copies that datagram's source address and source port into the destination pair.

The current pair drives the block's outputs directly, together with a sticky valid flag. The valid flag tells the transmit logic that a destination exists. A registered read port returns the pair through the same register offsets that the write path uses. The listening port is a build-time parameter, and the default is 3332.

Top module: `peer_dest_regs`

## Requirements
- R1: While `rst` is high, and on the first sampled cycle after it, `dest_ip`, `dest_port`, `dest_valid` and `cfg_rdata` are all zero.
- R2: A configuration write to offset 0 loads `cfg_wdata[31:0]` into `dest_ip`, visible after the next rising edge, and leaves `dest_port` unchanged.
- R3: A configuration write to offset 1 loads `cfg_wdata[15:0]` into `dest_port`, visible after the next rising edge, and leaves `dest_ip` unchanged.
- R4: A configuration write to any offset other than 0 or 1 changes none of `dest_ip`, `dest_port` or `dest_valid`.
- R5: When `hdr_valid` is high and `hdr_dst_port` equals `LISTEN_PORT`, the next rising edge loads `hdr_src_ip` into `dest_ip` and `hdr_src_port` into `dest_port`.
- R6: A header with `hdr_valid` high and any other `hdr_dst_port` leaves `dest_ip`, `dest_port` and `dest_valid` unchanged.
- R7: If a capture (R5) and a configuration write fall in the same cycle, the capture is applied to both fields and the configuration write is discarded.
- R8: `dest_valid` is low until the first accepted write (R2, R3) or capture (R5). After that it stays high until reset.
- R9: `cfg_rdata` is registered. One edge after `cfg_raddr` is presented, it shows `dest_ip` for offset 0, `dest_port` zero-extended for offset 1, and zero for every other offset. The values shown are those held before that edge.
- R10: While `hdr_valid` is low, the header fields have no effect, even when `hdr_dst_port` equals `LISTEN_PORT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write offset |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_raddr | input | ADDR_W | Read offset |
| cfg_rdata | output | DATA_W | Registered read data |
| hdr_valid | input | 1 | Parsed inbound header strobe |
| hdr_src_ip | input | 32 | Inbound source IPv4 address |
| hdr_src_port | input | 16 | Inbound source UDP port |
| hdr_dst_port | input | 16 | Inbound destination UDP port |
| dest_ip | output | 32 | Current destination IPv4 address |
| dest_port | output | 16 | Current destination UDP port |
| dest_valid | output | 1 | A destination has been set |

## Verification
Every result is due exactly one rising edge after its stimulus. Writes and captures appear on `dest_ip`, `dest_port` and `dest_valid` after that edge. `cfg_rdata` reflects the register values from before the same edge. The bench applies each stimulus at a falling edge, waits for one rising edge, and samples at the following falling edge. Before that edge it computes the expected register pair and read data from its own model, so each comparison falls in the single cycle in which the result is defined.

// File: rtl/peer_dest_pkg.sv
package peer_dest_pkg;
  localparam int IP_W     = 32;
  localparam int PORT_W   = 16;
  localparam int OFS_IP   = 0;
  localparam int OFS_PORT = 1;
  localparam int NUM_REGS = 2;

  typedef struct packed {
    logic [IP_W-1:0]   ip;
    logic [PORT_W-1:0] port;
  } peer_addr_t;
endpackage

// File: rtl/peer_dest_match.sv
module peer_dest_match #(
  parameter int LISTEN_PORT = 3332
) (
  input  logic        hdr_valid,
  input  logic [15:0] hdr_dst_port,
  output logic        cap_hit
);
  localparam logic [15:0] LISTEN_V = 16'(LISTEN_PORT);

  assign cap_hit = hdr_valid && (hdr_dst_port == LISTEN_V);
endmodule

// File: rtl/peer_dest_cfg_dec.sv
module peer_dest_cfg_dec
  import peer_dest_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic [NUM_REGS-1:0] wr_sel
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel[g] = cfg_wr && (cfg_addr == ADDR_W'(g));
  end
endmodule

// File: rtl/peer_dest_store.sv
module peer_dest_store
  import peer_dest_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_hit,
  input  peer_addr_t          cap_val,
  input  logic [NUM_REGS-1:0] wr_sel,
  input  logic [DATA_W-1:0]   wdata,
  output peer_addr_t          cur,
  output logic                valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= '0;
      valid <= 1'b0;
    end else if (cap_hit) begin
      // learned peer overrides a colliding configuration write
      cur   <= cap_val;
      valid <= 1'b1;
    end else begin
      if (wr_sel[OFS_IP])   cur.ip   <= wdata[IP_W-1:0];
      if (wr_sel[OFS_PORT]) cur.port <= wdata[PORT_W-1:0];
      if (|wr_sel)          valid    <= 1'b1;
    end
  end
endmodule

// File: rtl/peer_dest_rdmux.sv
module peer_dest_rdmux
  import peer_dest_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] raddr,
  input  peer_addr_t        cur,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (raddr)
        ADDR_W'(OFS_IP):   rdata <= DATA_W'(cur.ip);
        ADDR_W'(OFS_PORT): rdata <= DATA_W'(cur.port);
        default:           rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/peer_dest_regs.sv
module peer_dest_regs
  import peer_dest_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int LISTEN_PORT = 3332
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              hdr_valid,
  input  logic [31:0]       hdr_src_ip,
  input  logic [15:0]       hdr_src_port,
  input  logic [15:0]       hdr_dst_port,
  output logic [31:0]       dest_ip,
  output logic [15:0]       dest_port,
  output logic              dest_valid
);
  logic                cap_hit;
  logic [NUM_REGS-1:0] wr_sel;
  peer_addr_t          cap_val;
  peer_addr_t          cur;

  assign cap_val.ip   = hdr_src_ip;
  assign cap_val.port = hdr_src_port;

  peer_dest_match #(.LISTEN_PORT(LISTEN_PORT)) u_match (
    .hdr_valid   (hdr_valid),
    .hdr_dst_port(hdr_dst_port),
    .cap_hit     (cap_hit)
  );

  peer_dest_cfg_dec #(.ADDR_W(ADDR_W)) u_dec (
    .cfg_wr  (cfg_wr),
    .cfg_addr(cfg_addr),
    .wr_sel  (wr_sel)
  );

  peer_dest_store #(.DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .cap_hit(cap_hit),
    .cap_val(cap_val),
    .wr_sel (wr_sel),
    .wdata  (cfg_wdata),
    .cur    (cur),
    .valid  (dest_valid)
  );

  peer_dest_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk  (clk),
    .rst  (rst),
    .raddr(cfg_raddr),
    .cur  (cur),
    .rdata(cfg_rdata)
  );

  assign dest_ip   = cur.ip;
  assign dest_port = cur.port;
endmodule

// File: rtl/peer_dest_regs_chk.sv
module peer_dest_regs_chk #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int LISTEN_PORT = 3332
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [ADDR_W-1:0] cfg_raddr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              hdr_valid,
  input logic [31:0]       hdr_src_ip,
  input logic [15:0]       hdr_src_port,
  input logic [15:0]       hdr_dst_port,
  input logic [31:0]       dest_ip,
  input logic [15:0]       dest_port,
  input logic              dest_valid
);
  localparam logic [15:0] LP = 16'(LISTEN_PORT);

  p_ip_write_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == ADDR_W'(0) && !(hdr_valid && hdr_dst_port == LP))
    |=> (dest_ip == $past(cfg_wdata[31:0]) && $stable(dest_port)));

  p_port_write_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == ADDR_W'(1) && !(hdr_valid && hdr_dst_port == LP))
    |=> (dest_port == $past(cfg_wdata[15:0]) && $stable(dest_ip)));

  p_unmapped_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr > ADDR_W'(1) && !hdr_valid)
    |=> ($stable(dest_ip) && $stable(dest_port) && $stable(dest_valid)));

  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_dst_port == LP)
    |=> (dest_ip == $past(hdr_src_ip) && dest_port == $past(hdr_src_port) && dest_valid));

  p_other_port_r6: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_dst_port != LP && !cfg_wr)
    |=> ($stable(dest_ip) && $stable(dest_port) && $stable(dest_valid)));

  p_capture_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && hdr_valid && hdr_dst_port == LP)
    |=> (dest_ip == $past(hdr_src_ip) && dest_port == $past(hdr_src_port)));

  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    dest_valid |=> dest_valid);

  p_rd_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_raddr == ADDR_W'(1)) |=> (cfg_rdata[DATA_W-1:16] == '0));

  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!hdr_valid && !cfg_wr)
    |=> ($stable(dest_ip) && $stable(dest_port) && $stable(dest_valid)));
endmodule

bind peer_dest_regs peer_dest_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LISTEN_PORT(LISTEN_PORT)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
  .hdr_valid(hdr_valid), .hdr_src_ip(hdr_src_ip), .hdr_src_port(hdr_src_port),
  .hdr_dst_port(hdr_dst_port), .dest_ip(dest_ip), .dest_port(dest_port),
  .dest_valid(dest_valid)
);

// File: tb/sim_peer_dest_regs.sv
module sim_peer_dest_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int LP = 3332;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_raddr = '0;
  logic [DW-1:0] cfg_rdata;
  logic          hdr_valid = 1'b0;
  logic [31:0]   hdr_src_ip = '0;
  logic [15:0]   hdr_src_port = '0;
  logic [15:0]   hdr_dst_port = '0;
  logic [31:0]   dest_ip;
  logic [15:0]   dest_port;
  logic          dest_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_ip = '0;
  logic [15:0] m_port = '0;
  logic        m_valid = 1'b0;
  logic [31:0] m_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  peer_dest_regs #(.ADDR_W(AW), .DATA_W(DW), .LISTEN_PORT(LP)) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .hdr_valid(hdr_valid), .hdr_src_ip(hdr_src_ip), .hdr_src_port(hdr_src_port),
    .hdr_dst_port(hdr_dst_port), .dest_ip(dest_ip), .dest_port(dest_port),
    .dest_valid(dest_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(dest_ip == m_ip, req, "dest_ip", dest_ip, m_ip);
    chk(dest_port == m_port, req, "dest_port", {16'h0, dest_port}, {16'h0, m_port});
    chk(dest_valid == m_valid, req, "dest_valid", {31'h0, dest_valid}, {31'h0, m_valid});
    chk(cfg_rdata == m_rd, req, "cfg_rdata", cfg_rdata, m_rd);
  endtask

  // drive at a falling edge, model the next rising edge, sample at the falling edge after it
  task automatic step(input logic wr, input logic [AW-1:0] wa, input logic [31:0] wd,
                      input logic hv, input logic [31:0] sip, input logic [15:0] sp,
                      input logic [15:0] dp, input logic [AW-1:0] ra, input string req);
    bit hit;
    cfg_wr = wr; cfg_addr = wa; cfg_wdata = wd;
    hdr_valid = hv; hdr_src_ip = sip; hdr_src_port = sp; hdr_dst_port = dp;
    cfg_raddr = ra;
    m_rd = (ra == 0) ? m_ip : (ra == 1) ? {16'h0, m_port} : 32'h0;
    hit = hv && (dp == 16'(LP));
    if (hit) begin
      m_ip = sip; m_port = sp; m_valid = 1'b1;
    end else if (wr && wa == 0) begin
      m_ip = wd; m_valid = 1'b1;
    end else if (wr && wa == 1) begin
      m_port = wd[15:0]; m_valid = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cfg_wr = 1'b0; hdr_valid = 1'b0; cfg_raddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_ip = '0; m_port = '0; m_valid = 1'b0; m_rd = '0;
    compare("R1");
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    step(1'b0, '0, 32'h0, 1'b0, 32'h0, 16'h0, 16'h0, 4'd0, "R1");
    // nothing accepted yet: valid must stay low
    for (int a = 2; a < 16; a++)
      step(1'b1, AW'(a), 32'hDEAD0000 + 32'(a), 1'b0, 32'h0, 16'h0, 16'h0, AW'(a), "R4");
    step(1'b0, '0, 32'h0, 1'b1, 32'h11223344, 16'h5566, 16'(LP + 1), 4'd0, "R6");
    step(1'b0, '0, 32'h0, 1'b0, 32'h11223344, 16'h5566, 16'(LP), 4'd1, "R10");
    step(1'b0, '0, 32'h0, 1'b0, 32'h0, 16'h0, 16'h0, 4'd0, "R8");
    // first accepted write sets valid
    step(1'b1, 4'd1, 32'hFFFF_BEEF, 1'b0, 32'h0, 16'h0, 16'h0, 4'd1, "R3");
    step(1'b0, '0, 32'h0, 1'b0, 32'h0, 16'h0, 16'h0, 4'd1, "R9");
    step(1'b1, 4'd0, 32'hC0A8_0102, 1'b0, 32'h0, 16'h0, 16'h0, 4'd0, "R2");
    step(1'b0, '0, 32'h0, 1'b0, 32'h0, 16'h0, 16'h0, 4'd0, "R9");
    // sweep every offset with write and readback
    for (int a = 0; a < 16; a++) begin
      step(1'b1, AW'(a), 32'h01010101 * 32'(a + 1), 1'b0, 32'h0, 16'h0, 16'h0, AW'(a),
           (a == 0) ? "R2" : (a == 1) ? "R3" : "R4");
      for (int r = 0; r < 4; r++)
        step(1'b0, '0, 32'h0, 1'b0, 32'h0, 16'h0, 16'h0, AW'(r), "R9");
    end
    // sweep destination ports around the listening port
    for (int d = -8; d <= 8; d++) begin
      step(1'b0, '0, 32'h0, 1'b1, 32'h0A000000 | 32'(d + 100), 16'(d + 100) ^ 16'h5A5A,
           16'(LP + d), 4'd0, (d == 0) ? "R5" : "R6");
      step(1'b0, '0, 32'h0, 1'b0, 32'h0, 16'h0, 16'h0, 4'd1, "R9");
    end
    for (int d = 0; d < 16; d++)
      step(1'b0, '0, 32'h0, 1'b1, 32'h1 << (d * 2), 16'h1 << d, 16'h1 << d, 4'd0, "R6");
    // inactive header with matching port
    for (int d = 0; d < 4; d++)
      step(1'b0, '0, 32'h0, 1'b0, 32'hBAD0_0000 + 32'(d), 16'h0BAD, 16'(LP), 4'd0, "R10");
    // collisions between capture and configuration write
    for (int a = 0; a < 4; a++)
      step(1'b1, AW'(a), 32'h7777_0000 + 32'(a), 1'b1, 32'hAC10_0000 + 32'(a),
           16'h9000 + 16'(a), 16'(LP), AW'(a), "R7");
    // write with a non-matching header in the same cycle
    step(1'b1, 4'd0, 32'h0102_0304, 1'b1, 32'hFFFF_FFFF, 16'hFFFF, 16'(LP - 1), 4'd0, "R2");
    step(1'b1, 4'd1, 32'h0000_1234, 1'b1, 32'hFFFF_FFFF, 16'hFFFF, 16'(LP + 2), 4'd1, "R3");
    for (int i = 0; i < 4; i++)
      step(1'b0, '0, 32'h0, 1'b0, 32'h0, 16'h0, 16'h0, AW'(i), "R8");
    // reset mid-run clears everything, then capture re-arms valid
    @(negedge clk);
    do_reset();
    step(1'b0, '0, 32'h0, 1'b0, 32'h0, 16'h0, 16'h0, 4'd0, "R8");
    step(1'b0, '0, 32'h0, 1'b1, 32'h0A0B0C0D, 16'h4321, 16'(LP), 4'd0, "R5");
    step(1'b0, '0, 32'h0, 1'b0, 32'h0, 16'h0, 16'h0, 4'd0, "R9");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule